// File: doc/BRIEF.md
# Enable-Count Interrupt Pending Aggregator

This block collects a fixed set of level-type interrupt sources and turns them into one processor interrupt request. Each source may be gated by several enable bits spread over different registers. Register decoding is done elsewhere. That decoder sends this block one increment strobe when an enable bit covering the source is set, and one decrement strobe when such a bit is cleared. A source counts as enabled only when its enable count has reached the number of enable bits that cover it. It is pending when its input level is high and it is enabled.

A running tally of pending sources drives the request line. The line rises when the tally leaves zero and falls when it returns to zero. The processor can also ask which vector to take. A small query state machine has two states, `Q_IDLE` and `Q_ANSWER`:
- In `Q_IDLE`, a `query` pulse moves the machine to `Q_ANSWER` (transition *accept*).
- `Q_ANSWER` lasts exactly one cycle and always returns to `Q_IDLE` (transition *retire*).

During `Q_ANSWER` the block presents the vector of the lowest-indexed pending source. That vector is captured at the edge where the query was accepted.

Top module: `intc_agg`

## Requirements
- R1: After reset every source is deasserted with enable count zero, the pending tally is zero, `irq` is 0, `resp_ack` is 0 and the machine is in `Q_IDLE`.
- R2: At each clock an `en_inc` strobe alone raises a source's enable count by one, and an `en_dec` strobe alone lowers it by one. Both strobes together leave the count unchanged. The count saturates at zero and at the source's required count.
- R3: A source is pending only when its stored level is high and its enable count equals its required count. The pending state is updated at the same edge that samples the level and strobes.
- R4: A source's stored asserted state follows `src_level` at every clock edge. A rising level sets it and a falling level clears it.
- R5: The pending tally changes by the number of sources becoming pending minus the number ceasing to be pending. `irq` is high after an edge exactly when the tally is nonzero after that edge.
- R6: A query accepted while `imask` is 4'hF answers with `resp_valid` = 0.
- R7: Otherwise `resp_valid` is 1 when any source was pending at the accepting edge. `resp_vec` is then the vector of the lowest-indexed pending source. With no source pending, `resp_valid` is 0.
- R8: A `query` sampled in `Q_IDLE` gives `resp_ack` = 1 for exactly the next cycle. A `query` sampled in `Q_ANSWER` is ignored.
- R9: The fixed table gives source i a required enable count of (i mod 3) + 1 and a vector of 12'h100 + 12'h10 * i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | N_SRC | Interrupt level of each source |
| en_inc | input | N_SRC | One enable bit covering the source was set |
| en_dec | input | N_SRC | One enable bit covering the source was cleared |
| imask | input | 4 | Processor mask level |
| query | input | 1 | Processor asks for a vector |
| irq | output | 1 | Processor interrupt request |
| resp_ack | output | 1 | Query answer is present this cycle |
| resp_valid | output | 1 | Answer carries a vector |
| resp_vec | output | VEC_W | Vector of the lowest pending source |

## Verification
Two functions can fall in the same cycle. One is the tally update, when several sources change pending state at one edge and some gain while others drop. The other is a query accepted at that same edge, which must report the pending set from before the edge. Random level toggles and sparse enable strobes on all eight sources, with random queries and masks, provoke both coincidences. Each edge is judged against a bench model that computes the answer from the pre-edge pending set and computes `irq` from the post-edge tally.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;

    typedef enum logic {
        Q_IDLE,
        Q_ANSWER
    } qstate_e;

    // Required number of covering enable bits for source idx
    function automatic int src_need(input int idx);
        return (idx % 3) + 1;
    endfunction

    // Vector number handed out for source idx
    function automatic int src_vector(input int idx);
        return 32'h100 + 32'h10 * idx;
    endfunction

endpackage

// File: rtl/intc_src_slot.sv
module intc_src_slot #(
    parameter int NEED  = 1,
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic inc,
    input  logic dec,
    output logic pend,
    output logic rise,
    output logic fall
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(NEED);

    logic             asserted_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic             pend_n;

    always_comb begin
        cnt_n = cnt_q;
        if (inc && !dec && cnt_q != CNT_TOP) begin
            cnt_n = cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_n = cnt_q - 1'b1;
        end
        pend_n = level && (cnt_n == CNT_TOP);
        rise   = pend_n && !pend;
        fall   = !pend_n && pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asserted_q <= 1'b0;
            cnt_q      <= '0;
            pend       <= 1'b0;
        end else begin
            if (level != asserted_q) begin
                asserted_q <= level;
            end
            cnt_q <= cnt_n;
            pend  <= pend_n;
        end
    end

    // the stored level is only kept for visibility of the source state
    logic unused_ok;
    assign unused_ok = asserted_q;

endmodule

// File: rtl/intc_pend_tally.sv
module intc_pend_tally #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rise,
    input  logic [N-1:0]  fall,
    output logic [CW-1:0] tally,
    output logic          irq
);
    logic [CW-1:0] tally_n;

    always_comb begin
        tally_n = CW'(int'(tally) + $countones(rise) - $countones(fall));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally <= '0;
            irq   <= 1'b0;
        end else begin
            tally <= tally_n;
            if (tally == '0 && tally_n != '0) begin
                irq <= 1'b1;
            end else if (tally != '0 && tally_n == '0) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/intc_low_pick.sv
module intc_low_pick #(
    parameter int N     = 8,
    parameter int VEC_W = 12
) (
    input  logic [N-1:0]     pend,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    import intc_agg_pkg::*;

    logic [VEC_W-1:0] vec_tab [N];

    for (genvar g = 0; g < N; g++) begin : g_tab
        assign vec_tab[g] = VEC_W'(src_vector(g));
    end

    always_comb begin
        any = |pend;
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vec = vec_tab[i];
            end
        end
    end

endmodule

// File: rtl/intc_agg.sv
module intc_agg #(
    parameter int N_SRC = 8,
    parameter int VEC_W = 12,
    parameter int EN_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_level,
    input  logic [N_SRC-1:0] en_inc,
    input  logic [N_SRC-1:0] en_dec,
    input  logic [3:0]       imask,
    input  logic             query,
    output logic             irq,
    output logic             resp_ack,
    output logic             resp_valid,
    output logic [VEC_W-1:0] resp_vec
);
    import intc_agg_pkg::*;

    localparam int TW = $clog2(N_SRC + 1);

    logic [N_SRC-1:0] pend_vec;
    logic [N_SRC-1:0] rise_vec;
    logic [N_SRC-1:0] fall_vec;
    logic [TW-1:0]    pend_cnt;
    logic             pick_any;
    logic [VEC_W-1:0] pick_vec;
    qstate_e          state_q;
    qstate_e          state_n;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        intc_src_slot #(
            .NEED  (src_need(g)),
            .CNT_W (EN_W)
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .level (src_level[g]),
            .inc   (en_inc[g]),
            .dec   (en_dec[g]),
            .pend  (pend_vec[g]),
            .rise  (rise_vec[g]),
            .fall  (fall_vec[g])
        );
    end

    intc_pend_tally #(
        .N  (N_SRC),
        .CW (TW)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise_vec),
        .fall  (fall_vec),
        .tally (pend_cnt),
        .irq   (irq)
    );

    intc_low_pick #(
        .N     (N_SRC),
        .VEC_W (VEC_W)
    ) u_pick (
        .pend (pend_vec),
        .any  (pick_any),
        .vec  (pick_vec)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            Q_IDLE:   if (query) state_n = Q_ANSWER;
            Q_ANSWER: state_n = Q_IDLE;
            default:  state_n = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_ack   <= 1'b0;
            resp_valid <= 1'b0;
            resp_vec   <= '0;
        end else begin
            resp_ack <= (state_q == Q_IDLE) && query;
            if (state_q == Q_IDLE && query) begin
                resp_valid <= pick_any && (imask != 4'hF);
                resp_vec   <= (pick_any && imask != 4'hF) ? pick_vec : '0;
            end
        end
    end

endmodule

// File: rtl/intc_agg_chk.sv
module intc_agg_chk #(
    parameter int N_SRC = 8,
    parameter int TW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_level,
    input logic [N_SRC-1:0] pend,
    input logic [TW-1:0]    pend_cnt,
    input logic [3:0]       imask,
    input logic             query,
    input logic             irq,
    input logic             resp_ack,
    input logic             resp_valid
);
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_cnt != '0));                                          // R5
    AST_TALLY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_cnt) == $countones(pend));                               // R5
    AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(src_level)) == '0) || !$past(rst_n));              // R3
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ack |=> !resp_ack);                                           // R8
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_ack) |-> $past(query));                                 // R8
    AST_MASK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ack && $past(imask) == 4'hF) |-> !resp_valid);               // R6
    AST_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ack && resp_valid) |-> ($past(pend) != '0));                 // R7
endmodule

bind intc_agg intc_agg_chk #(
    .N_SRC (N_SRC),
    .TW    (TW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_level  (src_level),
    .pend       (pend_vec),
    .pend_cnt   (pend_cnt),
    .imask      (imask),
    .query      (query),
    .irq        (irq),
    .resp_ack   (resp_ack),
    .resp_valid (resp_valid)
);

// File: tb/intc_agg_tb.sv
module intc_agg_tb;
    localparam int N     = 8;
    localparam int VEC_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     src_level = '0;
    logic [N-1:0]     en_inc = '0;
    logic [N-1:0]     en_dec = '0;
    logic [3:0]       imask = '0;
    logic             query = 1'b0;
    logic             irq;
    logic             resp_ack;
    logic             resp_valid;
    logic [VEC_W-1:0] resp_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    int m_cnt [N];
    bit m_pend [N];
    bit m_busy;

    intc_agg u_dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .en_inc(en_inc),
        .en_dec(en_dec), .imask(imask), .query(query), .irq(irq),
        .resp_ack(resp_ack), .resp_valid(resp_valid), .resp_vec(resp_vec)
    );

    always #5 clk = ~clk;

    // R9 table
    function automatic int need_of(input int i);
        return (i % 3) + 1;
    endfunction
    function automatic int vec_of(input int i);
        return 'h100 + 'h10 * i;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = 0;
            m_pend[i] = 0;
        end
        m_busy = 0;
    endtask

    // apply current inputs for one edge and check the result
    task automatic step(input string irq_tag);
        bit exp_ack, exp_valid;
        int exp_vec, tally;
        exp_ack = query && !m_busy;
        exp_valid = 0;
        exp_vec = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_pend[i]) begin
                exp_valid = 1;
                exp_vec = vec_of(i);
            end
        end
        if (imask == 4'hF) begin
            exp_valid = 0;
            exp_vec = 0;
        end
        tally = 0;
        for (int i = 0; i < N; i++) begin
            if (en_inc[i] && !en_dec[i] && m_cnt[i] < need_of(i)) m_cnt[i]++;
            else if (en_dec[i] && !en_inc[i] && m_cnt[i] > 0) m_cnt[i]--;
            m_pend[i] = src_level[i] && (m_cnt[i] == need_of(i));
            tally += int'(m_pend[i]);
        end
        m_busy = exp_ack;
        @(posedge clk);
        #1;
        chk(irq_tag, int'(irq), int'(tally != 0));
        chk("R8 ack", int'(resp_ack), int'(exp_ack));
        if (exp_ack) begin
            chk(imask == 4'hF ? "R6 valid" : "R7 valid", int'(resp_valid), int'(exp_valid));
            if (exp_valid) chk("R7 vector", int'(resp_vec), exp_vec);
        end
        en_inc = '0;
        en_dec = '0;
        query = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1 irq", int'(irq), 0);
        chk("R1 ack", int'(resp_ack), 0);

        // R3: level without enable is not pending
        src_level[0] = 1'b1;
        step("R3 unenabled");
        // R3: one enable reaches need of 1
        en_inc[0] = 1'b1;
        step("R3 enabled");
        // R2: decrement below zero saturates
        en_dec[0] = 1'b1; step("R2 dec");
        en_dec[0] = 1'b1; step("R2 dec floor");
        en_inc[0] = 1'b1; step("R2 inc from floor");
        // R2: both strobes together hold the count
        en_inc[0] = 1'b1; en_dec[0] = 1'b1; step("R2 both");
        // R4: falling level clears pending
        src_level[0] = 1'b0; step("R4 fall");
        // R2: source 2 needs 3, overshoot then one dec disables
        src_level[2] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            en_inc[2] = 1'b1; step("R2 sat top");
        end
        en_dec[2] = 1'b1; step("R2 dec from top");
        en_inc[2] = 1'b1; step("R3 back at need");
        // R9/R7: source 5 needs 3 and answers 0x150 when lowest
        src_level[2] = 1'b0;
        src_level[5] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            en_inc[5] = 1'b1; step("R9 need");
        end
        imask = 4'h3; query = 1'b1; step("R5 hold");
        query = 1'b1; step("R8 ignored");
        imask = 4'hF; query = 1'b1; step("R6 mask");
        step("R5 idle");

        // random phase
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom % 6 == 0) src_level[i] = ~src_level[i];
                if ($urandom % 5 == 0) en_inc[i] = 1'b1;
                if ($urandom % 7 == 0) en_dec[i] = 1'b1;
            end
            imask = ($urandom % 5 == 0) ? 4'hF : 4'($urandom % 15);
            query = ($urandom % 3 == 0);
            step("R5 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule